// File: doc/BRIEF.md
# Biased Two-Way Install Selector with Static Way Prediction

This block decides where a newly filled line lands in a two-way set-associative DRAM cache, and steers lookups so that the first probe usually hits. Every address has a preferred way, taken from one tag bit. On a fill, a 16-bit pseudo-random sequence picks the preferred way with a programmable bias and the other way otherwise. Installs are skewed toward the preferred way, so a predictor that keeps no state can still be accurate.

On a lookup, the block always probes the preferred way first. If that probe misses, it probes the other way before it reports a miss. It reports how many probes each lookup used, so that the caller can measure prediction accuracy. Tag storage, data movement and replacement state belong to the surrounding cache controller.

Top module: `way_install_sel`

## Requirements
- R1: After reset `install_valid`, `probe_valid` and `lk_done` are 0 and `lk_ready` is 1. The bias threshold is 0xD99A (about 85 %) and the random state is 0xACE1.
- R2: The preferred way of an address is its bit `PREF_BIT` (default 12). Value 1 means way 1.
- R3: The random state is a Galois LFSR. Each step shifts right by one bit, and XORs 0xB400 into the state when the bit shifted out was 1. It steps once per fill and never on lookups or threshold writes.
- R4: A fill presented in cycle n gives `install_valid`=1 in cycle n+1. `install_way` is the preferred way when the random state used for that fill, taken before it steps, is below the threshold. Otherwise it is the other way.
- R5: A threshold write is clamped into the range 0x8000 to 0x10000. Writing 0x10000 or more makes every install go to the preferred way, which behaves as direct-mapped. Writing below 0x8000 gives a 50 % split.
- R6: A threshold written in cycle n applies to fills from cycle n+1 on.
- R7: A lookup accepted while `lk_ready`=1 gives a one-cycle `probe_valid` pulse in the next cycle, with `probe_way` equal to the preferred way.
- R8: A hit reported for the first probe ends the lookup with `lk_done`=1, `lk_hit`=1, `lk_way`=preferred and `lk_probes`=1. No second probe is issued.
- R9: A miss reported for the first probe gives a second `probe_valid` pulse to the other way in the next cycle. The response to that probe ends the lookup with `lk_probes`=2, `lk_way`=other way and `lk_hit` equal to that response.
- R10: While a lookup is in flight, `lk_ready` is 0 and new lookup requests are ignored.
- R11: `resp_valid` is ignored while no lookup is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_we | input | 1 | Bias threshold write strobe |
| thr_wdata | input | 17 | Threshold value, where 0x10000 means always preferred |
| fill_valid | input | 1 | Fill request |
| fill_addr | input | ADDR_W | Fill address |
| install_valid | output | 1 | Install decision valid |
| install_way | output | 1 | Chosen install way |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup address |
| lk_ready | output | 1 | Lookup engine idle |
| probe_valid | output | 1 | Tag probe request |
| probe_way | output | 1 | Way to probe |
| resp_valid | input | 1 | Probe result valid |
| resp_hit | input | 1 | Probe result was a hit |
| lk_done | output | 1 | Lookup finished |
| lk_hit | output | 1 | Lookup result is a hit |
| lk_way | output | 1 | Way that was probed last |
| lk_probes | output | 2 | Probes used, 1 or 2 |

## Verification
The hardest case to reach from the ports is an install that goes to the non-preferred way under the default bias. It happens for only about 15 % of the random states, and only at positions that depend on how many fills came earlier. The stimulus handles this by running long fill sequences while a bench model steps the same sequence from the stated polynomial and seed. Every decision is then known in advance. Lookups are interleaved with the fills to show that they leave the sequence alone. Forcing the threshold to each clamp limit turns the random choice into a fixed one that can be checked.

// File: rtl/way_steer_pkg.sv
package way_steer_pkg;

    localparam int RND_W = 16;
    localparam int THR_W = RND_W + 1;
    localparam logic [RND_W-1:0] RND_MASK  = 16'hB400;
    localparam logic [RND_W-1:0] RND_SEED  = 16'hACE1;
    localparam logic [THR_W-1:0] THR_FULL  = 17'h10000;
    localparam logic [THR_W-1:0] THR_HALF  = 17'h08000;
    localparam logic [THR_W-1:0] THR_RESET = 17'h0D99A;

    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_WAIT1 = 2'd1,
        LK_WAIT2 = 2'd2
    } lk_state_e;

    typedef struct packed {
        logic       done;
        logic       hit;
        logic       way;
        logic [1:0] probes;
    } lk_result_t;

    typedef struct packed {
        logic valid;
        logic way;
    } probe_t;

    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
        logic [RND_W-1:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ RND_MASK;
        return n;
    endfunction

    function automatic logic [THR_W-1:0] thr_clamp(input logic [THR_W-1:0] v);
        if (v > THR_FULL) return THR_FULL;
        if (v < THR_HALF) return THR_HALF;
        return v;
    endfunction

endpackage

// File: rtl/ws_rand.sv
module ws_rand
    import way_steer_pkg::*;
#(
    parameter logic [RND_W-1:0] SEED = RND_SEED
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [RND_W-1:0] state
);
    localparam logic [RND_W-1:0] SAFE_SEED = (SEED == '0) ? {{(RND_W-1){1'b0}}, 1'b1} : SEED;

    logic [RND_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)       state_q <= SAFE_SEED;
        else if (step) state_q <= rnd_step(state_q);
    end

    assign state = state_q;
endmodule

// File: rtl/ws_install.sv
module ws_install
    import way_steer_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PREF_BIT = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              thr_we,
    input  logic [THR_W-1:0]  thr_wdata,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [RND_W-1:0]  rnd,
    output logic              install_valid,
    output logic              install_way
);
    logic [THR_W-1:0] thr_q;
    logic             pref;
    logic             take_pref;
    probe_t           dec_q;

    always_ff @(posedge clk) begin
        if (rst)         thr_q <= THR_RESET;
        else if (thr_we) thr_q <= thr_clamp(thr_wdata);
    end

    assign pref      = fill_addr[PREF_BIT];
    assign take_pref = ({1'b0, rnd} < thr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else begin
            dec_q.valid <= fill_valid;
            if (fill_valid) dec_q.way <= take_pref ? pref : ~pref;
        end
    end

    assign install_valid = dec_q.valid;
    assign install_way   = dec_q.way;
endmodule

// File: rtl/ws_lookup.sv
module ws_lookup
    import way_steer_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PREF_BIT = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              resp_valid,
    input  logic              resp_hit,
    output logic              lk_ready,
    output probe_t            probe,
    output lk_result_t        result
);
    lk_state_e  st_q;
    logic       pref_q;
    probe_t     probe_q;
    lk_result_t res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= LK_IDLE;
            pref_q  <= 1'b0;
            probe_q <= '0;
            res_q   <= '0;
        end else begin
            probe_q.valid <= 1'b0;
            res_q.done    <= 1'b0;
            unique case (st_q)
                LK_IDLE: begin
                    if (lk_valid) begin
                        pref_q        <= lk_addr[PREF_BIT];
                        probe_q.valid <= 1'b1;
                        probe_q.way   <= lk_addr[PREF_BIT];
                        st_q          <= LK_WAIT1;
                    end
                end
                LK_WAIT1: begin
                    if (resp_valid) begin
                        if (resp_hit) begin
                            res_q <= '{done: 1'b1, hit: 1'b1, way: pref_q, probes: 2'd1};
                            st_q  <= LK_IDLE;
                        end else begin
                            probe_q.valid <= 1'b1;
                            probe_q.way   <= ~pref_q;
                            st_q          <= LK_WAIT2;
                        end
                    end
                end
                LK_WAIT2: begin
                    if (resp_valid) begin
                        res_q <= '{done: 1'b1, hit: resp_hit, way: ~pref_q, probes: 2'd2};
                        st_q  <= LK_IDLE;
                    end
                end
                default: st_q <= LK_IDLE;
            endcase
        end
    end

    assign lk_ready = (st_q == LK_IDLE);
    assign probe    = probe_q;
    assign result   = res_q;
endmodule

// File: rtl/way_install_sel.sv
module way_install_sel
    import way_steer_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PREF_BIT = 12,
    parameter logic [RND_W-1:0] SEED = RND_SEED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              thr_we,
    input  logic [16:0]       thr_wdata,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              install_valid,
    output logic              install_way,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_ready,
    output logic              probe_valid,
    output logic              probe_way,
    input  logic              resp_valid,
    input  logic              resp_hit,
    output logic              lk_done,
    output logic              lk_hit,
    output logic              lk_way,
    output logic [1:0]        lk_probes
);
    logic [RND_W-1:0] rnd;
    probe_t           probe;
    lk_result_t       result;

    ws_rand #(.SEED(SEED)) u_rand (
        .clk   (clk),
        .rst   (rst),
        .step  (fill_valid),
        .state (rnd)
    );

    ws_install #(.ADDR_W(ADDR_W), .PREF_BIT(PREF_BIT)) u_inst (
        .clk           (clk),
        .rst           (rst),
        .thr_we        (thr_we),
        .thr_wdata     (thr_wdata),
        .fill_valid    (fill_valid),
        .fill_addr     (fill_addr),
        .rnd           (rnd),
        .install_valid (install_valid),
        .install_way   (install_way)
    );

    ws_lookup #(.ADDR_W(ADDR_W), .PREF_BIT(PREF_BIT)) u_lk (
        .clk        (clk),
        .rst        (rst),
        .lk_valid   (lk_valid),
        .lk_addr    (lk_addr),
        .resp_valid (resp_valid),
        .resp_hit   (resp_hit),
        .lk_ready   (lk_ready),
        .probe      (probe),
        .result     (result)
    );

    assign probe_valid = probe.valid;
    assign probe_way   = probe.way;
    assign lk_done     = result.done;
    assign lk_hit      = result.hit;
    assign lk_way      = result.way;
    assign lk_probes   = result.probes;
endmodule

// File: rtl/ws_chk.sv
module ws_chk #(
    parameter int ADDR_W   = 32,
    parameter int PREF_BIT = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              fill_valid,
    input logic              install_valid,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              lk_ready,
    input logic              probe_valid,
    input logic              probe_way,
    input logic              resp_valid,
    input logic              lk_done,
    input logic              lk_hit,
    input logic [1:0]        lk_probes
);
    // R7
    first_probe_pref_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready) |=> (probe_valid && probe_way == $past(lk_addr[PREF_BIT])));

    // R4
    install_follows_fill_chk: assert property (@(posedge clk) disable iff (rst)
        install_valid |-> $past(fill_valid));

    // R8
    single_probe_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_done && lk_probes == 2'd1) |-> lk_hit);

    // R11
    idle_resp_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && lk_ready && !lk_valid) |=> (!probe_valid && !lk_done));

    // R9
    done_no_probe_chk: assert property (@(posedge clk) disable iff (rst)
        lk_done |-> (!probe_valid && (lk_probes == 2'd1 || lk_probes == 2'd2)));
endmodule

bind way_install_sel ws_chk #(.ADDR_W(ADDR_W), .PREF_BIT(PREF_BIT)) u_chk (.*);

// File: tb/sim_way_install_sel.sv
module sim_way_install_sel;
    localparam int ADDR_W = 32;
    localparam int PB     = 12;

    logic              clk = 1'b0;
    logic              rst;
    logic              thr_we;
    logic [16:0]       thr_wdata;
    logic              fill_valid;
    logic [ADDR_W-1:0] fill_addr;
    logic              install_valid, install_way;
    logic              lk_valid;
    logic [ADDR_W-1:0] lk_addr;
    logic              lk_ready, probe_valid, probe_way;
    logic              resp_valid, resp_hit;
    logic              lk_done, lk_hit, lk_way;
    logic [1:0]        lk_probes;

    always #2 clk = ~clk;

    way_install_sel #(.ADDR_W(ADDR_W), .PREF_BIT(PB)) u0 (.*);

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [15:0] m_rnd;
    logic [16:0] m_thr;

    typedef struct packed {
        logic [31:0] addr;
        logic        h1;
        logic        h2;
        logic [1:0]  probes;
        logic        hit;
        logic        way;
    } lvec_t;

    localparam lvec_t LV [8] = '{
        '{32'h0000_0040, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0},
        '{32'h0000_1040, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1},
        '{32'h0000_2000, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1},
        '{32'h0000_3000, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0},
        '{32'h0000_4000, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1},
        '{32'hFFFF_F000, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0},
        '{32'hABCD_E000, 1'b1, 1'b1, 2'd1, 1'b1, 1'b0},
        '{32'h0000_1FFF, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] m_step(input logic [15:0] s);
        logic [15:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ 16'hB400;
        return n;
    endfunction

    task automatic write_thr(input logic [16:0] v);
        @(negedge clk);
        thr_we = 1'b1; thr_wdata = v;
        @(negedge clk);
        thr_we = 1'b0;
        m_thr = (v > 17'h10000) ? 17'h10000 : (v < 17'h08000) ? 17'h08000 : v;
    endtask

    task automatic do_fill(input logic [31:0] a, input string req);
        logic exp_way;
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = a;
        exp_way = ({1'b0, m_rnd} < m_thr) ? a[PB] : ~a[PB];
        m_rnd = m_step(m_rnd);
        @(negedge clk);
        fill_valid = 1'b0;
        chk(install_valid && install_way == exp_way, req,
            {install_valid, install_way}, {1'b1, exp_way});
    endtask

    task automatic do_lookup(input lvec_t v, input bit poke_busy);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = v.addr;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(probe_valid && probe_way == v.addr[PB] && !lk_ready, "R7",
            {probe_valid, probe_way, lk_ready}, {1'b1, v.addr[PB], 1'b0});
        if (poke_busy) begin
            lk_valid = 1'b1; lk_addr = ~v.addr;
            @(negedge clk);
            lk_valid = 1'b0;
            chk(!probe_valid && !lk_ready && !lk_done, "R10",
                {probe_valid, lk_ready, lk_done}, 0);
        end
        resp_valid = 1'b1; resp_hit = v.h1;
        @(negedge clk);
        resp_valid = 1'b0;
        if (!v.h1) begin
            chk(probe_valid && probe_way == ~v.addr[PB] && !lk_done, "R9",
                {probe_valid, probe_way, lk_done}, {1'b1, ~v.addr[PB], 1'b0});
            resp_valid = 1'b1; resp_hit = v.h2;
            @(negedge clk);
            resp_valid = 1'b0;
        end else begin
            chk(!probe_valid, "R8", probe_valid, 0);
        end
        chk(lk_done && lk_hit == v.hit && lk_way == v.way && lk_probes == v.probes,
            (v.probes == 2'd1) ? "R8" : "R9",
            {lk_done, lk_hit, lk_way, lk_probes}, {1'b1, v.hit, v.way, v.probes});
        @(negedge clk);
        chk(lk_ready && !lk_done, "R10", {lk_ready, lk_done}, 2'b10);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int npref;
        rst = 1'b1; thr_we = 1'b0; thr_wdata = '0; fill_valid = 1'b0; fill_addr = '0;
        lk_valid = 1'b0; lk_addr = '0; resp_valid = 1'b0; resp_hit = 1'b0;
        m_rnd = 16'hACE1; m_thr = 17'h0D99A;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!install_valid && !probe_valid && !lk_done && lk_ready, "R1",
            {install_valid, probe_valid, lk_done, lk_ready}, 4'b0001);

        // R4 R3 R2 R1: default threshold and seed, alternating preferred bits
        for (int i = 0; i < 40; i++) do_fill({i[18:0], 13'h0} | (i[0] ? 32'h1000 : 32'h0), "R4");

        // R7 R8 R9: table of lookups
        for (int i = 0; i < 8; i++) do_lookup(LV[i], i == 2);

        // R3: lookups above did not step the sequence
        for (int i = 0; i < 20; i++) do_fill(32'h0000_1000 * i, "R3");

        // R11: response while idle
        @(negedge clk);
        resp_valid = 1'b1; resp_hit = 1'b1;
        @(negedge clk);
        resp_valid = 1'b0;
        chk(!probe_valid && !lk_done && lk_ready, "R11", {probe_valid, lk_done, lk_ready}, 3'b001);

        // R5: direct-mapped limit, with over-range clamp
        write_thr(17'h1FFFF);
        npref = 0;
        for (int i = 0; i < 64; i++) do_fill(32'h0000_1000 + 32'h4000 * i, "R5");
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            fill_valid = 1'b1; fill_addr = 32'h0000_1000;
            m_rnd = m_step(m_rnd);
            @(negedge clk);
            fill_valid = 1'b0;
            if (install_way == 1'b1) npref++;
        end
        chk(npref == 8, "R5", npref, 8);

        // R5 R6: low clamp to half, then new value applies next fill
        write_thr(17'h00000);
        for (int i = 0; i < 40; i++) do_fill(32'h0000_2000 * i, "R5");
        write_thr(17'h0C000);
        for (int i = 0; i < 40; i++) do_fill(32'h0000_3000 * i, "R6");

        // R6: back-to-back write then fill
        @(negedge clk);
        thr_we = 1'b1; thr_wdata = 17'h10000;
        @(negedge clk);
        thr_we = 1'b0; m_thr = 17'h10000;
        do_fill(32'h0000_0000, "R6");

        // R1: reset restores seed and threshold
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_rnd = 16'hACE1; m_thr = 17'h0D99A;
        for (int i = 0; i < 20; i++) do_fill(32'h0000_1000 * (i + 3), "R1");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule